// File: doc/BRIEF.md
# Rotate-and-Mask Insert Word Unit

This unit merges a rotated copy of one 32-bit word into another. The source word is rotated left by a 5-bit amount. A contiguous mask is then built from a begin index and an end index. The mask is contiguous modulo 32, so it may wrap past bit 31 back to bit 0. Where the mask is set, the new word takes the rotated source. Where the mask is clear, it keeps the old destination bit. Indices count from the most significant bit, so index 0 is the MSB.

The operation completes in one registered stage. When the caller also raises a record flag, the unit classifies the new word as a signed value against zero. The resulting three-bit condition field is qualified by its own valid strobe. When no recorded operation arrives, the last condition field stays in place.

Top module: `rmi_unit`

## Requirements
- R1: The source word is rotated left by `rot_amt` (0 to 31) before insertion; with a full mask, source 0x80000001 rotated by 1 gives 0x00000003, and rotation by 0 leaves the source unchanged.
- R2: For `mask_begin` <= `mask_end`, the mask has ones at indices begin through end inclusive and zeros elsewhere, where index i is vector bit 31-i (index 9 alone gives 0x00400000, index 0 alone gives 0x80000000).
- R3: For `mask_begin` > `mask_end`, the mask wraps: ones from begin to index 31 and from index 0 to end. When begin equals end+1 modulo 32, the mask is all ones.
- R4: Each result bit under a one in the mask equals the rotated source bit; each result bit under a zero equals the `dst_word` bit.
- R5: For a recorded operation, `cond_flags` is {lt, gt, eq} (bit 2 lt, bit 1 gt, bit 0 eq) from a signed comparison of the new result with zero, with exactly one bit set.
- R6: `cond_valid` is high in the cycle after an accepted operation with `record_en` high, and low in every other cycle.
- R7: `cond_flags` keeps its value across cycles that carry no recorded operation.
- R8: `result` and `out_valid` are updated one clock after `in_valid`; with `in_valid` low, `out_valid` falls to 0 and `result` holds.
- R9: During reset, `result`, `out_valid`, `cond_valid` and `cond_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| src_word | input | 32 | Word to rotate |
| dst_word | input | 32 | Current destination word |
| rot_amt | input | 5 | Left rotate amount |
| mask_begin | input | 5 | First mask index (MSB = 0) |
| mask_end | input | 5 | Last mask index (MSB = 0) |
| record_en | input | 1 | Request the condition field |
| result | output | 32 | New destination word |
| out_valid | output | 1 | Result updated last edge |
| cond_valid | output | 1 | Condition field updated last edge |
| cond_flags | output | 3 | {lt, gt, eq} of result versus zero |

## Verification
The assertions check the following on every cycle:
- the one-cycle latency of `out_valid` and `cond_valid`;
- that `result` and `cond_flags` hold when nothing updates them;
- that the condition field is one-hot and agrees with the sign and zero state of `result`;
- that bits outside the internal mask keep the destination value.

Some behaviours cannot be seen by those properties. The exact shape of the mask, the wrap case and the rotation itself appear only in the bench scenarios. These scenarios are an exhaustive sweep of begin/end pairs at rotations 0 and 31, plus random operands compared against the bench's own model.

// File: rtl/rmi_pkg.sv
package rmi_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cond_t;

  // left rotation through a doubled word
  function automatic word_t rotl(input word_t s, input idx_t amt);
    logic [2*WORD_W-1:0] dbl;
    dbl = {s, s} << amt;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  // is MSB-numbered position pos inside the begin..end span (wrapping)
  function automatic logic in_span(input idx_t b, input idx_t e, input idx_t pos);
    if (b <= e) return (pos >= b) && (pos <= e);
    else        return (pos >= b) || (pos <= e);
  endfunction

  function automatic cond_t sign_class(input word_t r);
    cond_t c;
    c.lt = r[WORD_W-1];
    c.eq = (r == '0);
    c.gt = !c.lt && !c.eq;
    return c;
  endfunction
endpackage

// File: rtl/rmi_rotator.sv
module rmi_rotator
  import rmi_pkg::*;
(
  input  word_t src,
  input  idx_t  amt,
  output word_t rotated
);
  always_comb rotated = rotl(src, amt);
endmodule

// File: rtl/rmi_mask_gen.sv
module rmi_mask_gen
  import rmi_pkg::*;
(
  input  idx_t  span_begin,
  input  idx_t  span_end,
  output word_t mask
);
  for (genvar k = 0; k < WORD_W; k++) begin : g_bit
    localparam idx_t POS = idx_t'(WORD_W - 1 - k);
    assign mask[k] = in_span(span_begin, span_end, POS);
  end
endmodule

// File: rtl/rmi_cond.sv
module rmi_cond
  import rmi_pkg::*;
(
  input  word_t value,
  output cond_t flags
);
  always_comb flags = sign_class(value);
endmodule

// File: rtl/rmi_unit.sv
module rmi_unit
  import rmi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] src_word,
  input  logic [31:0] dst_word,
  input  logic [4:0]  rot_amt,
  input  logic [4:0]  mask_begin,
  input  logic [4:0]  mask_end,
  input  logic        record_en,
  output logic [31:0] result,
  output logic        out_valid,
  output logic        cond_valid,
  output logic [2:0]  cond_flags
);
  word_t rot_word;
  word_t ins_mask;
  word_t merged;
  cond_t next_cond;
  logic  rec_fire;

  rmi_rotator u_rot (
    .src(src_word), .amt(rot_amt), .rotated(rot_word)
  );

  rmi_mask_gen u_mask (
    .span_begin(mask_begin), .span_end(mask_end), .mask(ins_mask)
  );

  always_comb merged = (rot_word & ins_mask) | (dst_word & ~ins_mask);

  rmi_cond u_cond (
    .value(merged), .flags(next_cond)
  );

  assign rec_fire = in_valid && record_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      out_valid  <= 1'b0;
      cond_valid <= 1'b0;
      cond_flags <= '0;
    end else begin
      out_valid  <= in_valid;
      cond_valid <= rec_fire;
      if (in_valid) result     <= merged;
      if (rec_fire) cond_flags <= next_cond;
    end
  end
endmodule

// File: rtl/rmi_unit_chk.sv
module rmi_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        record_en,
  input logic [31:0] dst_word,
  input logic [31:0] ins_mask,
  input logic [31:0] result,
  input logic        out_valid,
  input logic        cond_valid,
  input logic [2:0]  cond_flags
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r6_cond_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && record_en) |=> cond_valid);
  a_r6_cond_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && record_en) |=> !cond_valid);
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && record_en) |=> $stable(cond_flags));
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> ($countones(cond_flags) == 1));
  a_r5_sign_match: assert property (@(posedge clk) disable iff (!rst_n)
    cond_valid |-> (cond_flags[2] == result[31]) && (cond_flags[0] == (result == 32'h0)));
  a_r4_keep_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((result ^ $past(dst_word)) & ~$past(ins_mask)) == 32'h0));
  a_r3_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (ins_mask != 32'h0));
endmodule

bind rmi_unit rmi_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .record_en(record_en),
  .dst_word(dst_word), .ins_mask(ins_mask), .result(result),
  .out_valid(out_valid), .cond_valid(cond_valid), .cond_flags(cond_flags)
);

// File: tb/rmi_unit_tb_top.sv
`timescale 1ns/1ps
module rmi_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_word = '0;
  logic [31:0] dst_word = '0;
  logic [4:0]  rot_amt = '0;
  logic [4:0]  mask_begin = '0;
  logic [4:0]  mask_end = '0;
  logic        record_en = 1'b0;
  logic [31:0] result;
  logic        out_valid;
  logic        cond_valid;
  logic [2:0]  cond_flags;

  int checks = 0;
  int failures = 0;
  logic [2:0] exp_flags = 3'b000;
  bit done = 0;

  always #10 clk = ~clk;

  rmi_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
    .dst_word(dst_word), .rot_amt(rot_amt), .mask_begin(mask_begin),
    .mask_end(mask_end), .record_en(record_en), .result(result),
    .out_valid(out_valid), .cond_valid(cond_valid), .cond_flags(cond_flags)
  );

  // bench model, bit by bit
  function automatic logic [31:0] m_rot(input logic [31:0] s, input int r);
    logic [31:0] o;
    for (int j = 0; j < 32; j++) o[(j + r) % 32] = s[j];
    return o;
  endfunction

  function automatic logic [31:0] m_mask(input int b, input int e);
    logic [31:0] m = '0;
    int i = b;
    while (1) begin
      m[31 - i] = 1'b1;
      if (i == e) break;
      i = (i + 1) % 32;
    end
    return m;
  endfunction

  function automatic logic [2:0] m_cond(input logic [31:0] v);
    if ($signed(v) < 0) return 3'b100;
    if (v == 0)         return 3'b001;
    return 3'b010;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input string tag, input logic [31:0] s, input logic [31:0] d,
                    input int r, input int b, input int e, input bit rec);
    logic [31:0] exp_r;
    @(negedge clk);
    src_word = s; dst_word = d; rot_amt = 5'(r);
    mask_begin = 5'(b); mask_end = 5'(e); record_en = rec; in_valid = 1'b1;
    exp_r = (m_rot(s, r) & m_mask(b, e)) | (d & ~m_mask(b, e));
    if (rec) exp_flags = m_cond(exp_r);
    @(posedge clk); #2;
    in_valid = 1'b0;
    check(tag, result, exp_r);
    check("R8 out_valid", {31'b0, out_valid}, 32'd1);
    check("R6 cond_valid", {31'b0, cond_valid}, {31'b0, rec});
    check(rec ? "R5 cond_flags" : "R7 cond_flags", {29'b0, cond_flags}, {29'b0, exp_flags});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    check("R9 result", result, 32'h0);
    check("R9 valids", {30'b0, out_valid, cond_valid}, 32'h0);
    check("R9 cond_flags", {29'b0, cond_flags}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // directed
    op("R2 single bit 9", 32'hFFFFFFFF, 32'h0, 0, 9, 9, 1'b0);
    check("R2 single bit 9 value", result, 32'h00400000);
    op("R2 single bit 0", 32'hFFFFFFFF, 32'h0, 0, 0, 0, 1'b0);
    check("R2 single bit 0 value", result, 32'h80000000);
    op("R1 rotate by 1", 32'h80000001, 32'h0, 1, 0, 31, 1'b1);
    check("R1 rotate value", result, 32'h00000003);
    op("R1 rotate by 0", 32'h12345678, 32'hFFFFFFFF, 0, 0, 31, 1'b1);
    op("R3 all ones wrap", 32'hFFFFFFFF, 32'h0, 0, 5, 4, 1'b1);
    check("R3 all ones value", result, 32'hFFFFFFFF);
    op("R5 zero", 32'h0, 32'h0, 7, 0, 31, 1'b1);
    op("R5 negative", 32'h1, 32'h0, 31, 0, 31, 1'b1);
    op("R5 positive", 32'h1, 32'h0, 3, 0, 31, 1'b1);
    op("R7 no record", 32'h0, 32'hFFFFFFFF, 0, 0, 0, 1'b0);

    // R8 idle cycle: result holds, out_valid falls
    @(posedge clk); #2;
    check("R8 result hold", result, 32'h7FFFFFFF);
    check("R8 out_valid low", {31'b0, out_valid}, 32'h0);
    check("R6 cond_valid low", {31'b0, cond_valid}, 32'h0);
    check("R7 flags held idle", {29'b0, cond_flags}, {29'b0, exp_flags});

    // exhaustive begin/end at rotations 0 and 31
    for (int b = 0; b < 32; b++)
      for (int e = 0; e < 32; e++) begin
        op(b > e ? "R3 mask shape" : "R2 mask shape", 32'hFFFFFFFF, 32'h0, 0, b, e, 1'b0);
        op("R4 insert r0", $urandom, $urandom, 0, b, e, 1'($urandom));
        op("R4 insert r31", $urandom, $urandom, 31, b, e, 1'($urandom));
      end

    // random
    for (int n = 0; n < 3000; n++)
      op("R4 random", $urandom, $urandom, $urandom % 32, $urandom % 32,
         $urandom % 32, 1'($urandom));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule